// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds a small set of recently used page mappings and turns a virtual address into a physical address in the same cycle the request is presented. The incoming virtual page number is compared against every stored entry at once. On a match, the stored frame number is joined with the untranslated low address bits, and the entry's stored referenced and dirty bits come out alongside. The block also checks the entry's permission bits against the kind of access. An access that the permissions forbid is reported as a fault, separate from a miss.

When nothing matches, a miss output tells an external page-table walker to fetch the mapping and write it back through the refill port. A refill goes into the lowest-numbered empty slot. When every slot is full, a rotating hand picks the victim: it skips entries whose referenced bit is set and clears those bits as it passes. Hardware keeps the referenced and dirty bits up to date on every permitted hit. A flush empties the whole buffer in one cycle. A targeted invalidate removes the entry for one page. Duplicate matches are flagged.

Top module: `tlb_fa`

## Requirements
- R1: After reset, and in the cycle after `flush` is sampled high, every lookup misses. `flush` takes priority over a refill and an invalidate in the same cycle.
- R2: A lookup with `req_valid` high that matches a valid entry and is permitted raises `hit` in the same cycle. `pa` then equals {stored frame number, `req_va[OFF_W-1:0]`}, where OFF_W = log2(PAGE_BYTES).
- R3: If no valid entry matches, `miss` is high and `pa` is zero.
- R4: The permission field `fill_perm` uses bit0 for read, bit1 for write and bit2 for execute. `req_kind` is encoded as 0 for read, 1 for write and 2 for execute; code 3 always faults. A match whose required bit is clear raises `fault` instead of `hit`, with `pa` zero. At most one of `hit`, `miss` and `fault` is high.
- R5: `attr_ref` and `attr_dirty` show the matched entry's stored bits. A permitted hit sets the entry's referenced bit at the clock edge.
- R6: A permitted write hit sets the dirty bit. A faulting write leaves it unchanged. A refill loads the dirty bit from `fill_dirty` and sets the referenced bit.
- R7: A refill goes into the lowest-index invalid slot, and every other entry stays resident.
- R8: When all slots are valid, the refill victim is the first entry with a clear referenced bit, searched from the hand position upward with wrap-around. Referenced bits of the entries passed over are cleared. If every referenced bit is set, all of them are cleared and the slot at the hand is replaced. After the refill, the hand points one past the victim.
- R9: `inv_en` invalidates the entries whose page equals `inv_vpn` and leaves all other entries resident.
- R10: When more than one valid entry matches, `multi_hit` is high and the lowest-index entry supplies the result.
- R11: With `req_valid` low, `hit`, `miss`, `fault` and `multi_hit` are all low and the stored state is not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| inv_en | input | 1 | Invalidate the entry for one page |
| inv_vpn | input | VPN_W | Page to invalidate |
| fill_en | input | 1 | Write a refill entry |
| fill_vpn | input | VPN_W | Refill virtual page |
| fill_pfn | input | PFN_W | Refill frame number |
| fill_perm | input | 3 | Refill permissions {x,w,r} |
| fill_dirty | input | 1 | Refill dirty bit |
| req_valid | input | 1 | Lookup request |
| req_va | input | VA_W | Virtual address |
| req_kind | input | 2 | Access kind |
| hit | output | 1 | Permitted translation |
| miss | output | 1 | No matching entry |
| fault | output | 1 | Permission violation |
| multi_hit | output | 1 | Duplicate match |
| pa | output | PA_W | Physical address |
| attr_ref | output | 1 | Stored referenced bit of the match |
| attr_dirty | output | 1 | Stored dirty bit of the match |

## Verification
The bench builds the block with four entries, 4 KB pages and 20-bit addresses, which gives an 8-bit page space. With that configuration it can sweep every possible virtual page, both from the empty state and with a full buffer, and compare each result to the set of pages it has loaded. It walks all eight permission codes against all four access kinds. Four slots are few enough that a short sequence of refills moves the replacement hand through wrap-around, through a referenced entry that gets skipped, and through the case where every referenced bit is set, with the resident set checked after each step.

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int N          = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         inv_en,
  input  logic [VA_W-$clog2(PAGE_BYTES)-1:0] inv_vpn,
  input  logic                         fill_en,
  input  logic [VA_W-$clog2(PAGE_BYTES)-1:0] fill_vpn,
  input  logic [PA_W-$clog2(PAGE_BYTES)-1:0] fill_pfn,
  input  logic [2:0]                   fill_perm,
  input  logic                         fill_dirty,
  input  logic                         req_valid,
  input  logic [VA_W-1:0]              req_va,
  input  logic [1:0]                   req_kind,
  output logic                         hit,
  output logic                         miss,
  output logic                         fault,
  output logic                         multi_hit,
  output logic [PA_W-1:0]              pa,
  output logic                         attr_ref,
  output logic                         attr_dirty
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [VPN_W-1:0] tag_q  [N];
  logic [PFN_W-1:0] pfn_q  [N];
  logic [2:0]       perm_q [N];
  logic [N-1:0]     v_q, r_q, d_q;
  logic [IDX_W-1:0] hand_q;

  wire [VPN_W-1:0] req_vpn = req_va[VA_W-1:OFF_W];

  logic [N-1:0]     match, pass;
  logic [IDX_W-1:0] sel, free_idx, vic, wslot;
  logic             allowed, free_any, found;
  int               idx;

  always_comb begin
    sel = '0;
    for (int i = N-1; i >= 0; i--) begin
      match[i] = v_q[i] && (tag_q[i] == req_vpn);
      if (match[i]) sel = IDX_W'(i);
    end
  end

  always_comb
    case (req_kind)
      2'd0:    allowed = perm_q[sel][0];
      2'd1:    allowed = perm_q[sel][1];
      2'd2:    allowed = perm_q[sel][2];
      default: allowed = 1'b0;
    endcase

  wire any = req_valid && (|match);
  wire upd = any && allowed;

  assign hit        = upd;
  assign fault      = any && !allowed;
  assign miss       = req_valid && !(|match);
  assign multi_hit  = req_valid && ($countones(match) > 1);
  assign pa         = upd ? {pfn_q[sel], req_va[OFF_W-1:0]} : '0;
  assign attr_ref   = any && r_q[sel];
  assign attr_dirty = any && d_q[sel];

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N-1; i >= 0; i--)
      if (!v_q[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
  end

  always_comb begin
    found = 1'b0;
    vic   = hand_q;
    pass  = '0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(hand_q) + k) % N;
      if (!found) begin
        if (!r_q[idx]) begin
          found = 1'b1;
          vic   = IDX_W'(idx);
        end else pass[idx] = 1'b1;
      end
    end
  end

  assign wslot = free_any ? free_idx : vic;
  wire sweep = fill_en && !free_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q    <= '0;
      r_q    <= '0;
      d_q    <= '0;
      hand_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (flush) v_q[i] <= 1'b0;
        else if (fill_en && wslot == IDX_W'(i)) begin
          v_q[i] <= 1'b1;
          r_q[i] <= 1'b1;
          d_q[i] <= fill_dirty;
        end else begin
          if (inv_en && v_q[i] && tag_q[i] == inv_vpn) v_q[i] <= 1'b0;
          if (upd && sel == IDX_W'(i)) begin
            r_q[i] <= 1'b1;
            if (req_kind == 2'd1) d_q[i] <= 1'b1;
          end else if (sweep && pass[i]) r_q[i] <= 1'b0;
        end
      end
      if (!flush && sweep) hand_q <= IDX_W'((int'(vic) + 1) % N);
    end
  end

  always_ff @(posedge clk)
    for (int i = 0; i < N; i++)
      if (!flush && fill_en && wslot == IDX_W'(i)) begin
        tag_q[i]  <= fill_vpn;
        pfn_q[i]  <= fill_pfn;
        perm_q[i] <= fill_perm;
      end
endmodule

module tlb_fa_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            req_valid,
  input logic [VA_W-1:0] req_va,
  input logic            hit,
  input logic            miss,
  input logic            fault,
  input logic            multi_hit,
  input logic [PA_W-1:0] pa
);
  a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, miss, fault}));
  a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit && !fault && !multi_hit);
  a_r3_miss_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (miss || fault) |-> pa == '0);
  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> pa[OFF_W-1:0] == req_va[OFF_W-1:0]);
  a_r10_multi_is_match: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit |-> (hit || fault));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(hit || miss || fault || multi_hit));
endmodule

bind tlb_fa tlb_fa_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W($clog2(PAGE_BYTES))) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_va(req_va),
  .hit(hit), .miss(miss), .fault(fault), .multi_hit(multi_hit), .pa(pa));

// File: tb/tb_tlb_fa.sv
`timescale 1ns/100ps
module tb_tlb_fa;
  localparam int VA_W = 20, PA_W = 20, PB = 4096, N = 4;
  localparam int VW = 8, PW = 8;

  logic clk = 0, rst_n = 0;
  logic flush = 0, inv_en = 0, fill_en = 0, fill_dirty = 0, req_valid = 0;
  logic [VW-1:0] inv_vpn = 0, fill_vpn = 0;
  logic [PW-1:0] fill_pfn = 0;
  logic [2:0] fill_perm = 0;
  logic [VA_W-1:0] req_va = 0;
  logic [1:0] req_kind = 0;
  logic hit, miss, fault, multi_hit, attr_ref, attr_dirty;
  logic [PA_W-1:0] pa;

  int tests = 0, fails = 0;
  logic s_hit, s_miss, s_fault, s_multi, s_ref, s_dirty;
  logic [PA_W-1:0] s_pa;

  tlb_fa #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BYTES(PB), .N(N)) dut (.*);

  always #2 clk = ~clk;

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic probe(input logic [VW-1:0] v, input logic [11:0] off, input logic [1:0] k);
    @(negedge clk);
    req_valid = 1; req_va = {v, off}; req_kind = k;
    #1;
    s_hit = hit; s_miss = miss; s_fault = fault; s_multi = multi_hit;
    s_pa = pa; s_ref = attr_ref; s_dirty = attr_dirty;
    req_valid = 0;
  endtask

  task automatic access(input logic [VW-1:0] v, input logic [1:0] k);
    @(negedge clk);
    req_valid = 1; req_va = {v, 12'h0}; req_kind = k;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p, input logic [2:0] pm, input logic d);
    @(negedge clk);
    fill_en = 1; fill_vpn = v; fill_pfn = p; fill_perm = pm; fill_dirty = d;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1; @(negedge clk); flush = 0;
  endtask

  task automatic do_inv(input logic [VW-1:0] v);
    @(negedge clk); inv_en = 1; inv_vpn = v; @(negedge clk); inv_en = 0;
  endtask

  function automatic logic [PW-1:0] pfn_of(input logic [VW-1:0] v);
    return v ^ 8'hA5;
  endfunction

  logic [VW-1:0] set4 [4] = '{8'h10, 8'h23, 8'h5A, 8'hF1};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    @(negedge clk); #1;
    chk("R11 idle hit", hit, 0); chk("R11 idle miss", miss, 0);

    for (int v = 0; v < 256; v++) begin
      probe(VW'(v), 12'(v * 37), 0);
      chk("R1 reset miss", s_miss, 1);
      chk("R3 miss pa", s_pa, 0);
    end

    foreach (set4[i]) fill(set4[i], pfn_of(set4[i]), 3'b111, 0);
    for (int v = 0; v < 256; v++) begin
      logic inset;
      inset = 0;
      foreach (set4[i]) if (set4[i] == VW'(v)) inset = 1;
      probe(VW'(v), 12'((v * 91) ^ 12'hABC), 0);
      chk("R2 hit", s_hit, inset);
      chk("R3 miss", s_miss, !inset);
      chk("R2 pa", s_pa, inset ? {pfn_of(VW'(v)), 12'((v * 91) ^ 12'hABC)} : 20'h0);
      chk("R7 resident", s_multi, 0);
    end

    for (int p = 0; p < 8; p++) begin
      do_flush();
      fill(8'h44, 8'h99, 3'(p), 0);
      for (int k = 0; k < 4; k++) begin
        logic ok;
        ok = (k < 3) && p[k];
        probe(8'h44, 12'h123, 2'(k));
        chk("R4 hit", s_hit, ok);
        chk("R4 fault", s_fault, !ok);
        chk("R4 pa", s_pa, ok ? 20'h99123 : 20'h0);
      end
    end

    do_flush();
    fill(8'h30, 8'h01, 3'b001, 0);
    fill(8'h31, 8'h02, 3'b011, 0);
    access(8'h30, 1);
    probe(8'h30, 0, 0); chk("R6 faulted write keeps dirty", s_dirty, 0);
    access(8'h31, 1);
    probe(8'h31, 0, 0); chk("R6 write sets dirty", s_dirty, 1);
    fill(8'h32, 8'h03, 3'b111, 1);
    probe(8'h32, 0, 0); chk("R6 fill dirty", s_dirty, 1); chk("R6 fill ref", s_ref, 1);

    do_flush();
    probe(8'h31, 0, 0); chk("R1 flush miss", s_miss, 1);
    @(negedge clk); flush = 1; fill_en = 1; fill_vpn = 8'h77; fill_pfn = 8'h01; fill_perm = 3'b111;
    @(negedge clk); flush = 0; fill_en = 0;
    probe(8'h77, 0, 0); chk("R1 flush beats fill", s_miss, 1);

    foreach (set4[i]) fill(set4[i], pfn_of(set4[i]), 3'b111, 0);
    fill(8'hE0, 8'h0E, 3'b111, 0);
    probe(8'h10, 0, 0); chk("R8 all-ref victim at hand", s_miss, 1);
    probe(8'hE0, 0, 0); chk("R8 new resident", s_hit, 1); chk("R5 fill ref", s_ref, 1);
    probe(8'h23, 0, 0); chk("R8 ref cleared", s_ref, 0);
    probe(8'h23, 0, 0); chk("R11 probe no update", s_ref, 0);
    access(8'h5A, 0);
    probe(8'h5A, 0, 0); chk("R5 hit sets ref", s_ref, 1);
    fill(8'hE1, 8'h1E, 3'b111, 0);
    probe(8'h23, 0, 0); chk("R8 victim slot1", s_miss, 1);
    fill(8'hE2, 8'h2E, 3'b111, 0);
    probe(8'hF1, 0, 0); chk("R8 skip ref slot", s_miss, 1);
    probe(8'h5A, 0, 0); chk("R8 skipped resident", s_hit, 1); chk("R8 passed cleared", s_ref, 0);
    probe(8'hE0, 0, 0); chk("R8 slot0 kept", s_hit, 1);
    probe(8'hE1, 0, 0); chk("R8 slot1 kept", s_hit, 1);
    probe(8'hE2, 0, 0); chk("R8 slot3 new", s_pa, 20'h2E000);

    do_inv(8'hE1);
    probe(8'hE1, 0, 0); chk("R9 inv miss", s_miss, 1);
    probe(8'hE0, 0, 0); chk("R9 other kept", s_hit, 1);
    fill(8'hB0, 8'h0B, 3'b111, 0);
    probe(8'hB0, 0, 0); chk("R7 fill free slot", s_hit, 1);
    probe(8'hE0, 0, 0); chk("R7 kept E0", s_hit, 1);
    probe(8'h5A, 0, 0); chk("R7 kept 5A", s_hit, 1);
    probe(8'hE2, 0, 0); chk("R7 kept E2", s_hit, 1);

    do_flush();
    fill(8'h66, 8'h01, 3'b111, 0);
    fill(8'h66, 8'h02, 3'b111, 0);
    probe(8'h66, 12'h055, 0);
    chk("R10 multi", s_multi, 1);
    chk("R10 lowest index", s_pa, 20'h01055);
    probe(8'h67, 0, 0); chk("R10 no multi on miss", s_multi, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule